// File: doc/BRIEF.md
# I2C Arbitration Loss Handler

This block sits beside a bit-level I2C engine and watches every SCL-high sample point for loss of arbitration. A loss happens when the engine is driving a bit and leaves SDA released (drives 1), but the bus reads back 0. When that happens, the block does four things:

- it sets a sticky interrupt flag;
- it pulses a strobe that tells the engine to let go of any SDA or SCL line it holds low;
- it decides what the engine does next;
- it works the same way whether the engine currently acts as a master or as a slave.

Losing arbitration during a master's address byte is handled differently from losing it at any other time. In that case the block does not send the engine straight to idle. It keeps sampling SDA until all eight address bits have been seen, taking the bits already sent as well as the rest. It then compares the 7-bit address with the device's own address. On a match, it asks the engine to become a slave, and the captured read/write bit chooses slave transmitter or slave receiver. On a mismatch, it sends the engine to idle.

Top module: `i2c_arb_guard`

## Requirements
- R1: When `scl_rise` and `scl_high` are both 1, `sda_drive_en` is 1, `drv_sda` is 1 and `sda_in` is 0, `irq_arb_lost` is 1 and `release_pulse` is 1 in the next cycle. `release_pulse` lasts one cycle.
- R2: Detection works the same way whatever the value of `role_master`.
- R3: No loss is reported when the sample point is absent (`scl_rise` or `scl_high` low), when `sda_drive_en` is 0, or when `drv_sda` is 0.
- R4: No comparison is made in the acknowledge slot of a received byte, which is `bit_idx` = 8 with `byte_tx` = 0.
- R5: `irq_arb_lost` stays 1 until a cycle with `flag_clr` = 1. If a new loss and `flag_clr` occur in the same cycle, the flag is set.
- R6: A loss that is not in a master address phase (`addr_phase` and `role_master` both 1, `bit_idx` 0..7) raises `idle_pulse` in the same cycle as `release_pulse`.
- R7: A loss in a master address phase gives no `idle_pulse`. The block then samples SDA at each later sample point, whatever `sda_drive_en` is, until the eighth address bit. No further loss is detected during this capture.
- R8: The address byte is sent MSB first. `bit_idx` 0..6 carry address bits 6..0 and `bit_idx` 7 carries R/W. If the captured 7-bit address equals `own_addr`, `slave_req` pulses for one cycle right after the eighth bit's sample. `slave_rd` then takes the R/W bit, where 1 means the remote master reads and this device acts as slave transmitter.
- R9: If the captured address differs from `own_addr`, `idle_pulse` pulses for one cycle right after the eighth bit's sample, and `slave_req` stays 0.
- R10: A loss on the R/W bit itself decides at once: `slave_req` or `idle_pulse` appears in the same cycle as `release_pulse`.
- R11: After reset every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| role_master | input | 1 | Engine currently acts as master |
| addr_phase | input | 1 | Current byte is an address byte |
| byte_tx | input | 1 | Engine transmits the current byte's data bits |
| sda_drive_en | input | 1 | Engine is the driver of SDA for this bit |
| drv_sda | input | 1 | Level the engine puts on SDA (1 = released) |
| sda_in | input | 1 | Sampled SDA level |
| scl_rise | input | 1 | SCL rising indication |
| scl_high | input | 1 | SCL high indication |
| bit_idx | input | IDX_W | Bit position within the byte (8 = acknowledge) |
| own_addr | input | ADDR_W | Device's own slave address |
| flag_clr | input | 1 | Clears the sticky flag |
| irq_arb_lost | output | 1 | Sticky arbitration-lost flag |
| release_pulse | output | 1 | One-cycle strobe: release SDA and SCL |
| idle_pulse | output | 1 | One-cycle strobe: return to idle |
| slave_req | output | 1 | One-cycle strobe: enter slave mode |
| slave_rd | output | 1 | Slave direction (1 = slave transmitter) |

## Verification
The bench builds the block with its default parameters: a 7-bit address and a 4-bit bit index. With these values, arbitration can be lost at every position of the address byte, from early address bits to the R/W bit itself, and the acknowledge slot at index 8 can be tested against the compare gate. The address scenarios cover a matching address in both directions and a mismatching address. In one of them the bench keeps the drive enable high through the capture, which would produce a false loss if detection were still active.

// File: rtl/i2c_arb_pkg.sv
package i2c_arb_pkg;
  typedef enum logic {
    ARB_WATCH   = 1'b0,
    ARB_CAPTURE = 1'b1
  } arb_state_e;
endpackage

// File: rtl/i2c_arb_cmp.sv
// Bit-level compare: flags a loss when SDA was released but read low at the sample point.
module i2c_arb_cmp #(
  parameter int IDX_W   = 4,
  parameter int ACK_IDX = 8
) (
  input  logic             watch_en,
  input  logic             scl_rise,
  input  logic             scl_high,
  input  logic             sda_drive_en,
  input  logic             drv_sda,
  input  logic             sda_in,
  input  logic             byte_tx,
  input  logic [IDX_W-1:0] bit_idx,
  output logic             sample_pt,
  output logic             lost
);
  localparam logic [IDX_W-1:0] ACK_POS = IDX_W'(ACK_IDX);

  logic ack_rx_slot;

  always_comb begin
    sample_pt   = scl_rise & scl_high;
    ack_rx_slot = (bit_idx == ACK_POS) & ~byte_tx;
    lost        = watch_en & sample_pt & sda_drive_en & ~ack_rx_slot
                & drv_sda & ~sda_in;
  end
endmodule

// File: rtl/i2c_arb_addr_cap.sv
// Address byte capture: stores each sampled SDA bit at its MSB-first position.
module i2c_arb_addr_cap #(
  parameter int ADDR_W = 7,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic [IDX_W-1:0]  pos,
  input  logic              bit_in,
  output logic [ADDR_W:0]   byte_now
);
  localparam int BYTE_W = ADDR_W + 1;

  logic [BYTE_W-1:0] shreg_q;
  logic [BYTE_W-1:0] shreg_d;

  always_comb begin
    shreg_d = shreg_q;
    for (int i = 0; i < BYTE_W; i++) begin
      if (cap_en && (pos == IDX_W'(i))) begin
        shreg_d[BYTE_W-1-i] = bit_in;
      end
    end
    byte_now = shreg_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q <= '0;
    end else if (cap_en) begin
      shreg_q <= shreg_d;
    end
  end
endmodule

// File: rtl/i2c_arb_ctrl.sv
// Outcome sequencer: sticky flag, release strobe, idle or slave-entry decision.
module i2c_arb_ctrl
  import i2c_arb_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lost,
  input  logic              sample_pt,
  input  logic              addr_master,
  input  logic [IDX_W-1:0]  bit_idx,
  input  logic              flag_clr,
  input  logic [ADDR_W:0]   byte_now,
  input  logic [ADDR_W-1:0] own_addr,
  output arb_state_e        state,
  output logic [IDX_W-1:0]  cap_idx,
  output logic              irq_arb_lost,
  output logic              release_pulse,
  output logic              idle_pulse,
  output logic              slave_req,
  output logic              slave_rd
);
  localparam int               BYTE_W = ADDR_W + 1;
  localparam logic [IDX_W-1:0] LAST   = IDX_W'(BYTE_W - 1);

  arb_state_e       state_q, state_d;
  logic [IDX_W-1:0] cnt_q, cnt_d;
  logic             irq_q, irq_d;
  logic             rel_q, rel_d;
  logic             idle_q, idle_d;
  logic             sreq_q, sreq_d;
  logic             srd_q, srd_d;
  logic             decide;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    irq_d   = irq_q & ~flag_clr;
    rel_d   = 1'b0;
    idle_d  = 1'b0;
    sreq_d  = 1'b0;
    srd_d   = srd_q;
    decide  = 1'b0;
    case (state_q)
      ARB_WATCH: begin
        if (lost) begin
          irq_d = 1'b1;
          rel_d = 1'b1;
          if (addr_master && (bit_idx <= LAST)) begin
            if (bit_idx == LAST) begin
              decide = 1'b1;
            end else begin
              state_d = ARB_CAPTURE;
              cnt_d   = bit_idx + IDX_W'(1);
            end
          end else begin
            idle_d = 1'b1;
          end
        end
      end
      ARB_CAPTURE: begin
        if (sample_pt) begin
          if (cnt_q == LAST) begin
            decide  = 1'b1;
            state_d = ARB_WATCH;
          end else begin
            cnt_d = cnt_q + IDX_W'(1);
          end
        end
      end
      default: state_d = ARB_WATCH;
    endcase
    if (decide) begin
      if (byte_now[BYTE_W-1:1] == own_addr) begin
        sreq_d = 1'b1;
        srd_d  = byte_now[0];
      end else begin
        idle_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ARB_WATCH;
      cnt_q   <= '0;
      irq_q   <= 1'b0;
      rel_q   <= 1'b0;
      idle_q  <= 1'b0;
      sreq_q  <= 1'b0;
      srd_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      irq_q   <= irq_d;
      rel_q   <= rel_d;
      idle_q  <= idle_d;
      sreq_q  <= sreq_d;
      srd_q   <= srd_d;
    end
  end

  assign state         = state_q;
  assign cap_idx       = cnt_q;
  assign irq_arb_lost  = irq_q;
  assign release_pulse = rel_q;
  assign idle_pulse    = idle_q;
  assign slave_req     = sreq_q;
  assign slave_rd      = srd_q;

  assert_release_sets_flag_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rel_q |-> irq_q);
  assert_flag_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && !flag_clr) |=> irq_q);
  assert_capture_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ARB_CAPTURE && $past(state_q == ARB_CAPTURE)) |-> !rel_q);
  assert_single_outcome_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sreq_q, idle_q}));
  assert_slave_after_sample_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sreq_q |-> $past(sample_pt));
endmodule

// File: rtl/i2c_arb_guard.sv
module i2c_arb_guard
  import i2c_arb_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              role_master,
  input  logic              addr_phase,
  input  logic              byte_tx,
  input  logic              sda_drive_en,
  input  logic              drv_sda,
  input  logic              sda_in,
  input  logic              scl_rise,
  input  logic              scl_high,
  input  logic [IDX_W-1:0]  bit_idx,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              flag_clr,
  output logic              irq_arb_lost,
  output logic              release_pulse,
  output logic              idle_pulse,
  output logic              slave_req,
  output logic              slave_rd
);
  localparam int ACK_IDX = ADDR_W + 1;

  arb_state_e       state;
  logic [IDX_W-1:0] cap_idx;
  logic [IDX_W-1:0] cap_pos;
  logic             sample_pt;
  logic             lost;
  logic             addr_master;
  logic             cap_en;
  logic [ADDR_W:0]  byte_now;

  always_comb begin
    addr_master = addr_phase & role_master;
    cap_en  = sample_pt & (((state == ARB_WATCH) & addr_master) | (state == ARB_CAPTURE));
    cap_pos = (state == ARB_CAPTURE) ? cap_idx : bit_idx;
  end

  i2c_arb_cmp #(.IDX_W(IDX_W), .ACK_IDX(ACK_IDX)) u_cmp (
    .watch_en     (state == ARB_WATCH),
    .scl_rise     (scl_rise),
    .scl_high     (scl_high),
    .sda_drive_en (sda_drive_en),
    .drv_sda      (drv_sda),
    .sda_in       (sda_in),
    .byte_tx      (byte_tx),
    .bit_idx      (bit_idx),
    .sample_pt    (sample_pt),
    .lost         (lost)
  );

  i2c_arb_addr_cap #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_cap (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap_en   (cap_en),
    .pos      (cap_pos),
    .bit_in   (sda_in),
    .byte_now (byte_now)
  );

  i2c_arb_ctrl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .lost          (lost),
    .sample_pt     (sample_pt),
    .addr_master   (addr_master),
    .bit_idx       (bit_idx),
    .flag_clr      (flag_clr),
    .byte_now      (byte_now),
    .own_addr      (own_addr),
    .state         (state),
    .cap_idx       (cap_idx),
    .irq_arb_lost  (irq_arb_lost),
    .release_pulse (release_pulse),
    .idle_pulse    (idle_pulse),
    .slave_req     (slave_req),
    .slave_rd      (slave_rd)
  );

  assert_ack_slot_skip_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_rise && scl_high && (bit_idx == IDX_W'(ACK_IDX)) && !byte_tx) |=> !release_pulse);
  assert_direction_from_bus_R8: assert property (@(posedge clk) disable iff (!rst_n)
    slave_req |-> (slave_rd == $past(sda_in)));
  assert_no_sample_no_loss_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(scl_rise && scl_high) |=> !release_pulse);
endmodule

// File: tb/i2c_arb_guard_tb.sv
module i2c_arb_guard_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       role_master, addr_phase, byte_tx, sda_drive_en, drv_sda, sda_in;
  logic       scl_rise, scl_high, flag_clr;
  logic [3:0] bit_idx;
  logic [6:0] own_addr;
  logic       irq_arb_lost, release_pulse, idle_pulse, slave_req, slave_rd;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  i2c_arb_guard u_dut (
    .clk(clk), .rst_n(rst_n), .role_master(role_master), .addr_phase(addr_phase),
    .byte_tx(byte_tx), .sda_drive_en(sda_drive_en), .drv_sda(drv_sda), .sda_in(sda_in),
    .scl_rise(scl_rise), .scl_high(scl_high), .bit_idx(bit_idx), .own_addr(own_addr),
    .flag_clr(flag_clr), .irq_arb_lost(irq_arb_lost), .release_pulse(release_pulse),
    .idle_pulse(idle_pulse), .slave_req(slave_req), .slave_rd(slave_rd)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // One sample point; returns at the next falling edge with outputs updated.
  task automatic bit_step(input logic en, input logic drv, input logic sda,
                          input logic [3:0] idx, input logic rise, input logic high);
    @(negedge clk);
    sda_drive_en = en; drv_sda = drv; sda_in = sda; bit_idx = idx;
    scl_rise = rise; scl_high = high;
    @(negedge clk);
    scl_rise = 1'b0; scl_high = 1'b0; sda_drive_en = 1'b0; sda_in = 1'b1;
  endtask

  task automatic clear_flag();
    @(negedge clk); flag_clr = 1'b1;
    @(negedge clk); flag_clr = 1'b0;
  endtask

  task automatic t_reset();
    chk("R11", "irq", irq_arb_lost, 0);
    chk("R11", "release", release_pulse, 0);
    chk("R11", "idle", idle_pulse, 0);
    chk("R11", "slave_req", slave_req, 0);
    chk("R11", "slave_rd", slave_rd, 0);
  endtask

  task automatic t_master_data_loss();
    role_master = 1'b1; addr_phase = 1'b0; byte_tx = 1'b1;
    bit_step(1'b1, 1'b1, 1'b0, 4'd3, 1'b1, 1'b1);
    chk("R1", "irq", irq_arb_lost, 1);
    chk("R1", "release", release_pulse, 1);
    chk("R6", "idle", idle_pulse, 1);
    chk("R6", "slave_req", slave_req, 0);
    @(negedge clk);
    chk("R1", "release one cycle", release_pulse, 0);
    chk("R5", "irq held", irq_arb_lost, 1);
    repeat (3) @(negedge clk);
    chk("R5", "irq held later", irq_arb_lost, 1);
    clear_flag();
    chk("R5", "irq cleared", irq_arb_lost, 0);
  endtask

  task automatic t_set_beats_clear();
    role_master = 1'b1; addr_phase = 1'b0; byte_tx = 1'b1;
    @(negedge clk);
    sda_drive_en = 1'b1; drv_sda = 1'b1; sda_in = 1'b0; bit_idx = 4'd5;
    scl_rise = 1'b1; scl_high = 1'b1; flag_clr = 1'b1;
    @(negedge clk);
    scl_rise = 1'b0; scl_high = 1'b0; flag_clr = 1'b0; sda_drive_en = 1'b0; sda_in = 1'b1;
    chk("R5", "set wins over clear", irq_arb_lost, 1);
    clear_flag();
  endtask

  task automatic t_slave_loss();
    role_master = 1'b0; addr_phase = 1'b0; byte_tx = 1'b1;
    bit_step(1'b1, 1'b1, 1'b0, 4'd0, 1'b1, 1'b1);
    chk("R2", "slave irq", irq_arb_lost, 1);
    chk("R2", "slave release", release_pulse, 1);
    chk("R2", "slave idle", idle_pulse, 1);
    clear_flag();
    // Slave role during an address byte is not the master address rule.
    addr_phase = 1'b1;
    bit_step(1'b1, 1'b1, 1'b0, 4'd2, 1'b1, 1'b1);
    chk("R6", "slave addr idle", idle_pulse, 1);
    clear_flag();
  endtask

  task automatic t_no_compare();
    role_master = 1'b1; addr_phase = 1'b0; byte_tx = 1'b1;
    bit_step(1'b1, 1'b1, 1'b0, 4'd1, 1'b0, 1'b1);
    chk("R3", "no rise release", release_pulse, 0);
    bit_step(1'b1, 1'b1, 1'b0, 4'd1, 1'b1, 1'b0);
    chk("R3", "no high release", release_pulse, 0);
    bit_step(1'b0, 1'b1, 1'b0, 4'd1, 1'b1, 1'b1);
    chk("R3", "not driving release", release_pulse, 0);
    bit_step(1'b1, 1'b0, 1'b0, 4'd1, 1'b1, 1'b1);
    chk("R3", "driving low release", release_pulse, 0);
    chk("R3", "irq untouched", irq_arb_lost, 0);
  endtask

  task automatic t_ack_slot();
    role_master = 1'b0; addr_phase = 1'b0; byte_tx = 1'b0;
    bit_step(1'b1, 1'b1, 1'b0, 4'd8, 1'b1, 1'b1);
    chk("R4", "ack slot release", release_pulse, 0);
    chk("R4", "ack slot irq", irq_arb_lost, 0);
    byte_tx = 1'b1;
  endtask

  // Address byte, MSB first, {addr[6:0], rw}; loss expected at bit 'at'.
  task automatic addr_run(input string req, input logic [7:0] ours, input logic [7:0] bus,
                          input int at, input logic jam);
    role_master = 1'b1; addr_phase = 1'b1; byte_tx = 1'b1;
    for (int i = 0; i < 8; i++) begin
      if (i <= at) bit_step(1'b1, ours[7-i], bus[7-i], 4'(i), 1'b1, 1'b1);
      else         bit_step(jam, 1'b1, bus[7-i], 4'(i), 1'b1, 1'b1);
      if (i == at) chk("R7", {req, " release at loss"}, release_pulse, 1);
      if (i > at)  chk("R7", {req, " no release in capture"}, release_pulse, 0);
      if (i < 7) begin
        chk("R7", {req, " no idle mid byte"}, idle_pulse, 0);
        chk("R7", {req, " no slave mid byte"}, slave_req, 0);
      end
    end
  endtask

  task automatic t_addr_match_read();
    own_addr = 7'h2A;
    addr_run("read", 8'h57, 8'h55, 6, 1'b0);
    chk("R8", "slave_req", slave_req, 1);
    chk("R8", "slave_rd", slave_rd, 1);
    chk("R8", "idle", idle_pulse, 0);
    @(negedge clk);
    chk("R8", "slave_req one cycle", slave_req, 0);
    clear_flag();
  endtask

  task automatic t_addr_match_write_jam();
    own_addr = 7'h2A;
    addr_run("write", 8'h74, 8'h54, 2, 1'b1);
    chk("R8", "slave_req", slave_req, 1);
    chk("R8", "slave_rd", slave_rd, 0);
    clear_flag();
  endtask

  task automatic t_addr_mismatch();
    own_addr = 7'h2A;
    addr_run("mismatch", 8'h6B, 8'h2B, 1, 1'b0);
    chk("R9", "idle", idle_pulse, 1);
    chk("R9", "slave_req", slave_req, 0);
    @(negedge clk);
    chk("R9", "idle one cycle", idle_pulse, 0);
    clear_flag();
  endtask

  task automatic t_rw_loss();
    own_addr = 7'h2A;
    addr_run("rw", 8'h55, 8'h54, 7, 1'b0);
    chk("R10", "release", release_pulse, 1);
    chk("R10", "slave_req", slave_req, 1);
    chk("R10", "slave_rd", slave_rd, 0);
    chk("R10", "idle", idle_pulse, 0);
    clear_flag();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    rst_n = 1'b0; role_master = 1'b0; addr_phase = 1'b0; byte_tx = 1'b1;
    sda_drive_en = 1'b0; drv_sda = 1'b1; sda_in = 1'b1; scl_rise = 1'b0;
    scl_high = 1'b0; bit_idx = '0; own_addr = 7'h2A; flag_clr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_master_data_loss();
    t_set_beats_clear();
    t_slave_loss();
    t_no_compare();
    t_ack_slot();
    t_addr_match_read();
    t_addr_match_write_jam();
    t_addr_mismatch();
    t_rw_loss();
    repeat (2) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      finish_run();
    end
  end
endmodule